// File: doc/BRIEF.md
# Fixed-Priority Eight-Line Interrupt Controller

This block gathers eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt output toward a processor. When the processor acknowledges, the block returns a vector number and records the granted line as being in service. Software programs the block through a small register port. Each input line can sense either rising edges or high levels.

Before the block can deliver anything, software must write four setup words in a fixed order. The first word sets the mode. The second sets the vector base. The third holds the cascade configuration. The fourth selects options such as automatic end-of-interrupt.

After setup, software uses operation words for three jobs:

- writing the mask,
- retiring in-service levels with specific or non-specific end-of-interrupt commands,
- choosing whether a status read returns the pending-request register or the in-service register.

Cascading is only stored here. The cascade byte is kept and can be read back, but it has no effect on routing.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the mask, in-service, request, trigger and cascade registers read as zero, the read selection points at the request register, and `int_out` is low.
- R2: A write to address 0 with bit 4 set is the mode word. It must be followed by three writes to address 1, taken in this order: vector base, cascade byte, option byte. `int_out` stays low until the option byte has been accepted. Until the mode word has been written, address-1 writes are ignored.
- R3: On acknowledge, `vec_out` equals the vector base with its low three bits replaced by the granted line number. Any base value works, for example 0x20 maps line 0 to 0x20, and 0x28 maps lines 0..7 to 0x28..0x2F.
- R4: Once setup is complete, an address-1 write loads the mask. A 1 bit blocks its line and a 0 bit enables it. The mask reads back at address 1. A request that arrives while its line is masked is kept, and it is delivered once the line is unmasked.
- R5: Line 0 has the highest priority. The granted line is the lowest-numbered unmasked pending request whose number is below every in-service line. A request at or below the highest in-service level does not raise `int_out`.
- R6: An acknowledge clears the granted request bit. If option bit 1 (automatic end-of-interrupt) is 0, the acknowledge also sets the matching in-service bit, and that bit stays set until an end-of-interrupt command. If option bit 1 is 1, the in-service register does not change.
- R7: Writing 0x60 plus a level (0..7) to address 0 clears only that in-service bit. Writing 0x20 to address 0 clears the highest-priority in-service bit.
- R8: Writing 0x0B to address 0 makes address-0 reads return the in-service register. Writing 0x0A makes them return the request register. The choice persists until it is rewritten or a new mode word arrives.
- R9: Address 2 holds the trigger register, with 0 meaning edge and 1 meaning level for each line. An edge line requests only on a rising edge. A level line requests for as long as it stays high. Bit 3 of the mode word loads every trigger bit with its own value.
- R10: The cascade byte from the third setup word reads back unchanged at address 3.
- R11: A new mode word clears the mask, in-service and request registers and resets the read selection. It also blocks `int_out` until setup completes again.
- R12: An acknowledge with no grantable request returns the base with low bits 7 and leaves the request and in-service registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 data, 2 trigger |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address: 0 status, 1 mask, 2 trigger, 3 cascade |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Registered interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector captured at the last acknowledge |

## Verification
The hardest state to reach from the ports is nested service. In that state, several in-service bits are set together while a lower-priority request waits behind them. Only then do the priority ceiling and the two kinds of end-of-interrupt show their differences.

The stimulus gets there step by step. It acknowledges a mid-priority line with automatic end-of-interrupt off, raises a lower line that must stay blocked, and then raises a higher line that must pre-empt. It then retires the in-service levels one command at a time and reads the in-service register after each step. A pairwise sweep over all 28 line pairs, with masking and vector checks run for every line and for several bases, covers the ordinary paths.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [2:0] {
    PH_WAIT_MODE,
    PH_WAIT_BASE,
    PH_WAIT_CASC,
    PH_WAIT_OPT,
    PH_RUN
  } phase_t;

  // register port addresses
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;
  localparam logic [1:0] A_CASC = 2'd3;

  // command word field positions
  localparam int F_INIT    = 4;
  localparam int F_OP3     = 3;
  localparam int F_LVL_ALL = 3;
  localparam int F_AEOI    = 1;

  // end-of-interrupt command codes (top three bits)
  localparam logic [2:0] EOI_SPEC    = 3'b011;
  localparam logic [2:0] EOI_NONSPEC = 3'b001;

  // read-select codes (low two bits)
  localparam logic [1:0] RS_IRR = 2'b10;
  localparam logic [1:0] RS_ISR = 2'b11;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lines_in,
  input  logic [LINES-1:0] trig,
  input  logic [LINES-1:0] clr_onehot,
  input  logic             clear_all,
  output logic [LINES-1:0] irr
);

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] irr_q;
  logic [LINES-1:0] irr_d;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_comb begin
        if (trig[g]) begin
          irr_d[g] = lines_in[g];
        end else begin
          irr_d[g] = (irr_q[g] & ~clr_onehot[g]) | (lines_in[g] & ~prev_q[g]);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= lines_in;
      if (clear_all) begin
        irr_q <= '0;
      end else begin
        irr_q <= irr_d;
      end
    end
  end

  assign irr = irr_q;

  // edge lines gain a request bit only after a rising edge (R9)
  assert_edge_only_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((irr_q & ~$past(irr_q) & ~$past(trig) &
               ~($past(lines_in) & ~$past(prev_q))) == '0));

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter  int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] isr,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx,
  output logic [LINES-1:0] sel_onehot,
  output logic [LINES-1:0] top_isr_onehot
);

  logic             isr_any;
  logic [IDX_W-1:0] isr_low;
  logic [LINES-1:0] ceiling;
  logic [LINES-1:0] cand;

  always_comb begin
    isr_low = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (isr[i]) isr_low = IDX_W'(i);
    end
  end

  assign isr_any        = |isr;
  assign top_isr_onehot = isr & (~isr + LINES'(1));
  assign ceiling        = isr_any ? ((LINES'(1) << isr_low) - LINES'(1)) : '1;
  assign cand           = irr & ~mask & ceiling;
  assign sel_onehot     = cand & (~cand + LINES'(1));
  assign sel_valid      = |cand;

  always_comb begin
    sel_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (cand[i]) sel_idx = IDX_W'(i);
    end
  end

  // a grant never targets a masked or already in-service line (R4, R5)
  assert_grant_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ((sel_onehot & mask) == '0));
  assert_grant_not_served_R5: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ((sel_onehot & isr) == '0 && (sel_onehot & irr) != '0));

endmodule

// File: rtl/irq_prog_regs.sv
module irq_prog_regs
  import irq_prio_pkg::*;
#(
  parameter  int LINES  = 8,
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [1:0]              rd_addr,
  input  logic [LINES-1:0]        irr,
  input  logic                    ack_take,
  input  logic [LINES-1:0]        sel_onehot,
  input  logic [LINES-1:0]        top_isr_onehot,
  output logic                    run,
  output logic                    restart,
  output logic                    aeoi,
  output logic [LINES-1:0]        mask,
  output logic [LINES-1:0]        trig,
  output logic [LINES-1:0]        isr,
  output logic [DATA_W-IDX_W-1:0] base_hi,
  output logic [DATA_W-1:0]       rd_data
);

  phase_t                  phase_q;
  logic [LINES-1:0]        mask_q;
  logic [LINES-1:0]        trig_q;
  logic [LINES-1:0]        isr_q;
  logic [LINES-1:0]        isr_d;
  logic [LINES-1:0]        eoi_clr;
  logic [LINES-1:0]        isr_set;
  logic [DATA_W-IDX_W-1:0] base_q;
  logic [DATA_W-1:0]       casc_q;
  logic [DATA_W-1:0]       rd_q;
  logic                    aeoi_q;
  logic                    show_isr_q;

  logic cmd_wr, mode_wr, op_wr, eoi_spec, eoi_ns, sel_wr, data_wr, trig_wr;

  assign run      = (phase_q == PH_RUN);
  assign cmd_wr   = wr_en && (wr_addr == A_CMD);
  assign mode_wr  = cmd_wr && wr_data[F_INIT];
  assign op_wr    = cmd_wr && !wr_data[F_INIT] && run;
  assign eoi_spec = op_wr && !wr_data[F_OP3] && (wr_data[DATA_W-1 -: 3] == EOI_SPEC);
  assign eoi_ns   = op_wr && !wr_data[F_OP3] && (wr_data[DATA_W-1 -: 3] == EOI_NONSPEC);
  assign sel_wr   = op_wr && wr_data[F_OP3];
  assign data_wr  = wr_en && (wr_addr == A_DATA);
  assign trig_wr  = wr_en && (wr_addr == A_TRIG);

  always_comb begin
    eoi_clr = '0;
    if (eoi_spec) eoi_clr = LINES'(1) << wr_data[IDX_W-1:0];
    else if (eoi_ns) eoi_clr = top_isr_onehot;
  end

  assign isr_set = (ack_take && !aeoi_q) ? sel_onehot : '0;
  assign isr_d   = mode_wr ? '0 : ((isr_q & ~eoi_clr) | isr_set);

  // setup sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_WAIT_MODE;
    end else if (mode_wr) begin
      phase_q <= PH_WAIT_BASE;
    end else if (data_wr) begin
      case (phase_q)
        PH_WAIT_BASE: phase_q <= PH_WAIT_CASC;
        PH_WAIT_CASC: phase_q <= PH_WAIT_OPT;
        PH_WAIT_OPT:  phase_q <= PH_RUN;
        default:      phase_q <= phase_q;
      endcase
    end
  end

  // configuration and status registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      trig_q     <= '0;
      isr_q      <= '0;
      base_q     <= '0;
      casc_q     <= '0;
      aeoi_q     <= 1'b0;
      show_isr_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (mode_wr) begin
        mask_q     <= '0;
        trig_q     <= {LINES{wr_data[F_LVL_ALL]}};
        show_isr_q <= 1'b0;
      end else if (trig_wr) begin
        trig_q <= wr_data[LINES-1:0];
      end
      if (data_wr) begin
        case (phase_q)
          PH_WAIT_BASE: base_q <= wr_data[DATA_W-1:IDX_W];
          PH_WAIT_CASC: casc_q <= wr_data;
          PH_WAIT_OPT:  aeoi_q <= wr_data[F_AEOI];
          PH_RUN:       mask_q <= wr_data[LINES-1:0];
          default:      ;
        endcase
      end
      if (sel_wr) begin
        if (wr_data[1:0] == RS_IRR) show_isr_q <= 1'b0;
        else if (wr_data[1:0] == RS_ISR) show_isr_q <= 1'b1;
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr)
        A_CMD:   rd_q <= show_isr_q ? DATA_W'(isr_q) : DATA_W'(irr);
        A_DATA:  rd_q <= DATA_W'(mask_q);
        A_TRIG:  rd_q <= DATA_W'(trig_q);
        default: rd_q <= casc_q;
      endcase
    end
  end

  assign restart = mode_wr;
  assign aeoi    = aeoi_q;
  assign mask    = mask_q;
  assign trig    = trig_q;
  assign isr     = isr_q;
  assign base_hi = base_q;
  assign rd_data = rd_q;

  // specific end-of-interrupt retires the named level (R7)
  assert_spec_eoi_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_spec && !ack_take) |=> !isr_q[$past(wr_data[IDX_W-1:0])]);

  // automatic end-of-interrupt leaves in-service untouched on acknowledge (R6)
  assert_aeoi_isr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_take && aeoi_q && !wr_en) |=> (isr_q == $past(isr_q)));

  // a new mode word empties mask and in-service (R11)
  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (isr_q == '0 && mask_q == '0 && !run));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter  int LINES  = 8,
  parameter  int DATA_W = 8,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LINES-1:0]  irq_in,
  output logic              int_out,
  input  logic              ack,
  output logic [DATA_W-1:0] vec_out
);

  logic                    run, restart, aeoi;
  logic [LINES-1:0]        mask, trig, isr, irr;
  logic [LINES-1:0]        sel_onehot, top_isr_onehot, clr_onehot;
  logic [IDX_W-1:0]        sel_idx;
  logic                    sel_valid, ack_take;
  logic [DATA_W-IDX_W-1:0] base_hi;
  logic                    int_q;
  logic [DATA_W-1:0]       vec_q;

  assign ack_take   = ack && run && sel_valid;
  assign clr_onehot = ack_take ? sel_onehot : '0;

  irq_req_capture #(.LINES(LINES)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .lines_in   (irq_in),
    .trig       (trig),
    .clr_onehot (clr_onehot),
    .clear_all  (restart),
    .irr        (irr)
  );

  irq_prio_resolve #(.LINES(LINES)) u_resolve (
    .clk            (clk),
    .rst            (rst),
    .irr            (irr),
    .mask           (mask),
    .isr            (isr),
    .sel_valid      (sel_valid),
    .sel_idx        (sel_idx),
    .sel_onehot     (sel_onehot),
    .top_isr_onehot (top_isr_onehot)
  );

  irq_prog_regs #(.LINES(LINES), .DATA_W(DATA_W)) u_regs (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .rd_addr        (rd_addr),
    .irr            (irr),
    .ack_take       (ack_take),
    .sel_onehot     (sel_onehot),
    .top_isr_onehot (top_isr_onehot),
    .run            (run),
    .restart        (restart),
    .aeoi           (aeoi),
    .mask           (mask),
    .trig           (trig),
    .isr            (isr),
    .base_hi        (base_hi),
    .rd_data        (rd_data)
  );

  // registered interrupt request and vector
  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= 1'b0;
      vec_q <= '0;
    end else begin
      int_q <= run && sel_valid;
      if (ack && run) begin
        vec_q <= sel_valid ? {base_hi, sel_idx} : {base_hi, {IDX_W{1'b1}}};
      end
    end
  end

  assign int_out = int_q;
  assign vec_out = vec_q;

  // no interrupt while setup is incomplete (R2)
  assert_blocked_in_setup_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !int_out);

  // a raised interrupt always had an unmasked pending source (R4)
  assert_int_has_source_R4: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past((irr & ~mask) != '0));

  // acknowledge without auto-EOI moves exactly the grant into service (R6)
  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !aeoi && !wr_en) |=> ((isr & ~$past(isr)) == $past(sel_onehot)));

  // spurious acknowledge yields the lowest-priority vector (R12)
  assert_spurious_vec_R12: assert property (@(posedge clk) disable iff (rst)
    (ack && run && !sel_valid) |=> (vec_out[IDX_W-1:0] == '1 && isr == $past(isr)));

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] irq_in;
  logic       int_out;
  logic       ack;
  logic [7:0] vec_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .irq_in (irq_in), .int_out (int_out), .ack (ack), .vec_out (vec_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; v = vec_out;
    @(negedge clk);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] base, input logic [7:0] casc,
                       input logic [7:0] opt, input logic lvl);
    do_wr(2'd0, 8'h11 | (lvl ? 8'h08 : 8'h00));
    do_wr(2'd1, base);
    do_wr(2'd1, casc);
    do_wr(2'd1, opt);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] bases [4] = '{8'h20, 8'h28, 8'h48, 8'hF8};
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; irq_in = '0; ack = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 int", int_out, 0);
    for (int a = 0; a < 4; a++) begin
      do_rd(2'(a), v); check("R1 reg", v, 0);
    end

    // R2 setup order; writes to address 1 before the mode word are ignored
    do_wr(2'd1, 8'h55);
    do_rd(2'd1, v); check("R2 pre-mode write ignored", v, 0);
    do_wr(2'd0, 8'h11);
    pulse(8'h04);
    do_wr(2'd1, 8'h20);
    do_wr(2'd1, 8'h04);
    settle(); check("R2 blocked before word 4", int_out, 0);
    do_wr(2'd1, 8'h00);
    settle(); check("R2 int after word 4", int_out, 1);
    do_ack(v); check("R2 vector", v, 8'h22);
    do_rd(2'd3, v); check("R10 cascade byte", v, 8'h04);
    do_wr(2'd0, 8'h0B); do_rd(2'd0, v); check("R8 isr read", v, 8'h04);
    do_wr(2'd0, 8'h62); do_rd(2'd0, v); check("R7 spec eoi", v, 8'h00);

    // R3 vector sweep with several bases, auto-EOI on (R6)
    foreach (bases[b]) begin
      setup(bases[b], 8'h02, 8'h02, 1'b0);
      do_rd(2'd3, v); check("R10 cascade byte", v, 8'h02);
      for (int i = 0; i < 8; i++) begin
        pulse(8'(1 << i));
        check("R3 int raised", int_out, 1);
        do_ack(v);
        check("R3 vector", v, int'((bases[b] & 8'hF8) | 8'(i)));
        check("R6 request cleared", int_out, 0);
      end
      do_wr(2'd0, 8'h0B); do_rd(2'd0, v); check("R6 aeoi isr empty", v, 0);
    end

    // R5 pairwise priority, base 0x28
    setup(8'h28, 8'h00, 8'h02, 1'b0);
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        pulse(8'(1 << i) | 8'(1 << j));
        do_ack(v); check("R5 higher first", v, 8'h28 + i);
        do_ack(v); check("R5 lower second", v, 8'h28 + j);
      end
    end

    // R4 masking per line
    for (int k = 0; k < 8; k++) begin
      do_wr(2'd1, 8'(1 << k));
      pulse(8'(1 << k));
      check("R4 masked line quiet", int_out, 0);
      do_rd(2'd1, v); check("R4 mask readback", v, 1 << k);
      do_wr(2'd1, 8'h00);
      settle(); check("R4 unmask delivers", int_out, 1);
      do_ack(v); check("R4 vector", v, 8'h28 + k);
    end

    // R12 spurious acknowledge
    do_ack(v); check("R12 spurious vector", v, 8'h2F);
    do_wr(2'd0, 8'h0A); do_rd(2'd0, v); check("R12 irr unchanged", v, 0);

    // nested service, auto-EOI off (R5 R6 R7 R8)
    setup(8'h40, 8'h00, 8'h00, 1'b0);
    pulse(8'h08); do_ack(v); check("R6 vector 3", v, 8'h43);
    pulse(8'h20); check("R5 lower blocked", int_out, 0);
    pulse(8'h02); check("R5 higher preempts", int_out, 1);
    do_ack(v); check("R5 vector 1", v, 8'h41);
    do_wr(2'd0, 8'h0B); do_rd(2'd0, v); check("R6 isr nested", v, 8'h0A);
    do_wr(2'd0, 8'h61); do_rd(2'd0, v); check("R7 spec clears one", v, 8'h08);
    settle(); check("R5 still blocked", int_out, 0);
    do_wr(2'd0, 8'h0A); do_rd(2'd0, v); check("R8 irr read", v, 8'h20);
    do_wr(2'd0, 8'h20); settle(); check("R7 nonspec unblocks", int_out, 1);
    do_ack(v); check("R7 vector 5", v, 8'h45);
    do_wr(2'd0, 8'h0B); do_rd(2'd0, v); check("R8 isr", v, 8'h20);

    // R11 re-init clears state
    do_wr(2'd1, 8'h81);
    do_wr(2'd0, 8'h11);
    do_rd(2'd1, v); check("R11 mask cleared", v, 0);
    do_rd(2'd0, v); check("R11 select reset to irr", v, 0);
    pulse(8'h40);
    do_wr(2'd1, 8'h40); do_wr(2'd1, 8'h00);
    settle(); check("R11 blocked", int_out, 0);
    do_wr(2'd1, 8'h00); settle(); check("R11 int after setup", int_out, 1);
    do_wr(2'd0, 8'h0B); do_rd(2'd0, v); check("R11 isr cleared", v, 0);
    do_ack(v); check("R11 vector", v, 8'h46);

    // R9 trigger modes
    setup(8'h20, 8'h00, 8'h02, 1'b1);
    do_rd(2'd2, v); check("R9 mode word sets all level", v, 8'hFF);
    do_wr(2'd2, 8'h10); do_rd(2'd2, v); check("R9 trigger readback", v, 8'h10);
    @(negedge clk); irq_in = 8'h10; settle();
    check("R9 level raises", int_out, 1);
    do_ack(v); check("R9 level vector", v, 8'h24);
    settle(); check("R9 level holds", int_out, 1);
    @(negedge clk); irq_in = 8'h00; settle();
    check("R9 level drops", int_out, 0);
    @(negedge clk); irq_in = 8'h20; settle();
    do_ack(v); check("R9 edge vector", v, 8'h25);
    settle(); check("R9 edge no repeat", int_out, 0);
    @(negedge clk); irq_in = 8'h00;
    do_wr(2'd2, 8'h00); do_rd(2'd2, v); check("R9 all edge", v, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule